// File: doc/BRIEF.md
# Dual-Input Non-Retriggerable One-Shot

This block is a synchronous monostable pulse generator. It has two trigger inputs of opposite edge polarity. One is active-low and fires on a falling edge. The other is active-high and fires on a rising edge. Each input also acts as an enable for the other: it only lets the other one fire while it rests in its own asserted state.

Once fired, the block drives `q_o` high, and its complement `q_no` low, for a number of clock cycles. That count is latched from the selected width source at the moment of firing. While the pulse runs, the block ignores all input activity. An active-low clear cuts the pulse short in the same cycle.

The width comes either straight from a cycle-count input or from a helper mode. The helper mode scales an R-by-C operand product by 0.7 in fixed point and rounds the result to whole cycles.

Top module: `dual_edge_oneshot`

## Requirements
- R1: While `rst_ni` is low, `q_o` is 0 and `q_no` is 1.
- R2: With `trig_b_i` high, a falling edge on `trig_a_ni` raises `q_o` in the third clock edge after the input changes (two synchronizer stages plus the pulse register). `q_o` then stays high for exactly the effective width in cycles.
- R3: With `trig_a_ni` low, a rising edge on `trig_b_i` starts the same pulse with the same latency and length.
- R4: `trig_a_ni` held high blocks every rising edge on `trig_b_i`, and `trig_b_i` held low blocks every falling edge on `trig_a_ni`. No pulse starts in either case.
- R5: Trigger edges that arrive while a pulse is running neither restart nor extend it.
- R6: `clr_ni` low forces `q_o` to 0 and `q_no` to 1 without waiting for a clock edge, and ends the pulse in progress.
- R7: Trigger edges seen while `clr_ni` is low are discarded, and releasing `clr_ni` does not start a pulse by itself.
- R8: When `rc_mode_i` is 0, the effective width is `width_i`, and a value of 0 gives a one-cycle pulse.
- R9: The width is latched when the pulse starts. Changing `width_i` during a pulse leaves that pulse unchanged.
- R10: The pulse length does not depend on how long the trigger input stays in its active state, whether shorter or longer than the pulse.
- R11: When `rc_mode_i` is 1, the effective width is (`r_val_i`·`c_val_i`·179 + 128) >> 8. The result saturates at 2^WIDTH_W−1, and a result of 0 becomes 1.
- R12: `q_no` is always the bitwise complement of `q_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_ni | input | 1 | Overriding clear, active low |
| trig_a_ni | input | 1 | Falling-edge trigger; holding it high inhibits the other trigger |
| trig_b_i | input | 1 | Rising-edge trigger; holding it low inhibits the other trigger |
| rc_mode_i | input | 1 | 0: width from `width_i`; 1: width from the R·C helper |
| width_i | input | WIDTH_W | Pulse width in clock cycles |
| r_val_i | input | R_W | Resistance-style operand for the helper |
| c_val_i | input | C_W | Capacitance-style operand for the helper |
| q_o | output | 1 | Pulse output |
| q_no | output | 1 | Complement of `q_o` |

## Verification
The assertions check four things on every cycle:
- `q_o` and `q_no` stay complementary.
- A clock edge that saw clear low leaves the pulse off.
- A pulse starts only after a cycle in which clear was high.
- A high run never outlasts the width latched at firing, and a run that clear did not cut matches that width exactly.

Only the bench scenarios can show which input patterns fire or are inhibited, the three-edge start latency, and the helper arithmetic. The same applies to a width change or a short trigger leaving the pulse unchanged, and to a clear release creating no pulse.

// File: rtl/dual_edge_oneshot_pkg.sv
package dual_edge_oneshot_pkg;
  // 0.7 scaled by 2^RC_F, fixed-point constant for the helper width
  localparam int RC_F = 8;
  localparam int RC_K = 179;
  localparam int RC_K_W = 8;

  typedef enum logic {
    WSRC_DIRECT = 1'b0,
    WSRC_RC     = 1'b1
  } wsrc_e;
endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
  parameter int unsigned N = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/oneshot_trig.sv
module oneshot_trig (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_n_i,
  input  logic b_i,
  input  logic clr_ni,
  input  logic busy_i,
  output logic fire_o
);
  logic a_prev_q, b_prev_q;
  logic a_fall, b_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_prev_q <= 1'b1;
      b_prev_q <= 1'b0;
    end else begin
      a_prev_q <= a_n_i;
      b_prev_q <= b_i;
    end
  end

  // each edge qualified by the other input's enabling level
  assign a_fall = a_prev_q & ~a_n_i & b_i;
  assign b_rise = ~b_prev_q & b_i & ~a_n_i;
  assign fire_o = clr_ni & ~busy_i & (a_fall | b_rise);
endmodule

// File: rtl/oneshot_width.sv
module oneshot_width
  import dual_edge_oneshot_pkg::*;
#(
  parameter int unsigned WIDTH_W = 10,
  parameter int unsigned R_W = 6,
  parameter int unsigned C_W = 6
) (
  input  wsrc_e              src_i,
  input  logic [WIDTH_W-1:0] width_i,
  input  logic [R_W-1:0]     r_i,
  input  logic [C_W-1:0]     c_i,
  output logic [WIDTH_W-1:0] eff_w_o
);
  localparam int unsigned PROD_W = R_W + C_W;
  localparam int unsigned SC_W = PROD_W + RC_K_W + 1;
  localparam int unsigned Q_W = SC_W - RC_F;

  logic [PROD_W-1:0]  rc_prod;
  logic [SC_W-1:0]    scaled;
  logic [Q_W-1:0]     q_val;
  logic [WIDTH_W-1:0] rc_w, raw_w;

  assign rc_prod = PROD_W'(r_i) * PROD_W'(c_i);
  assign scaled  = SC_W'(rc_prod) * SC_W'(RC_K) + SC_W'(1 << (RC_F - 1));
  assign q_val   = scaled[SC_W-1:RC_F];

  if (Q_W > WIDTH_W) begin : g_sat
    assign rc_w = (|q_val[Q_W-1:WIDTH_W]) ? '1 : q_val[WIDTH_W-1:0];
  end else begin : g_fit
    assign rc_w = WIDTH_W'(q_val);
  end

  assign raw_w   = (src_i == WSRC_RC) ? rc_w : width_i;
  assign eff_w_o = (raw_w == '0) ? WIDTH_W'(1) : raw_w;
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int unsigned WIDTH_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_ni,
  input  logic               fire_i,
  input  logic [WIDTH_W-1:0] eff_w_i,
  output logic               active_o
);
  logic               active_q;
  logic [WIDTH_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!clr_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (fire_i) begin
      active_q <= 1'b1;
      cnt_q    <= eff_w_i - WIDTH_W'(1);
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - WIDTH_W'(1);
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/dual_edge_oneshot.sv
module dual_edge_oneshot
  import dual_edge_oneshot_pkg::*;
#(
  parameter int unsigned WIDTH_W = 10,
  parameter int unsigned R_W = 6,
  parameter int unsigned C_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_ni,
  input  logic               trig_a_ni,
  input  logic               trig_b_i,
  input  logic               rc_mode_i,
  input  logic [WIDTH_W-1:0] width_i,
  input  logic [R_W-1:0]     r_val_i,
  input  logic [C_W-1:0]     c_val_i,
  output logic               q_o,
  output logic               q_no
);
  logic [1:0]         sync_in, sync_out;
  logic               fire, active;
  logic [WIDTH_W-1:0] eff_w;

  assign sync_in = {trig_b_i, trig_a_ni};

  oneshot_sync #(.N(2), .RST_VAL(2'b01)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sync_in),
    .q_o    (sync_out)
  );

  oneshot_trig u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_n_i  (sync_out[0]),
    .b_i    (sync_out[1]),
    .clr_ni (clr_ni),
    .busy_i (active),
    .fire_o (fire)
  );

  oneshot_width #(.WIDTH_W(WIDTH_W), .R_W(R_W), .C_W(C_W)) u_width (
    .src_i   (wsrc_e'(rc_mode_i)),
    .width_i (width_i),
    .r_i     (r_val_i),
    .c_i     (c_val_i),
    .eff_w_o (eff_w)
  );

  oneshot_timer #(.WIDTH_W(WIDTH_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_ni   (clr_ni),
    .fire_i   (fire),
    .eff_w_i  (eff_w),
    .active_o (active)
  );

  // clear overrides without waiting for a clock edge
  assign q_o  = active & clr_ni;
  assign q_no = ~q_o;
endmodule

// File: rtl/dual_edge_oneshot_chk.sv
module dual_edge_oneshot_chk #(
  parameter int unsigned WIDTH_W = 10
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               clr_ni,
  input logic               q_o,
  input logic               q_no,
  input logic               fire_i,
  input logic [WIDTH_W-1:0] eff_w_i
);
  logic [WIDTH_W:0]   run_q;
  logic [WIDTH_W-1:0] exp_q;
  logic               cut_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      exp_q <= '0;
      cut_q <= 1'b0;
    end else begin
      run_q <= q_o ? run_q + 1'b1 : '0;
      if (fire_i) exp_q <= eff_w_i;
      if (fire_i) cut_q <= 1'b0;
      else if (!clr_ni) cut_q <= 1'b1;
    end
  end

  p_complement_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_no == ~q_o);

  p_clear_ends_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(clr_ni) |-> !q_o);

  p_no_start_in_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_o) |-> $past(clr_ni));

  p_no_extend_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o |-> run_q < {1'b0, exp_q});

  p_exact_len_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(q_o) && !cut_q && clr_ni) |-> run_q == {1'b0, exp_q});
endmodule

bind dual_edge_oneshot dual_edge_oneshot_chk #(.WIDTH_W(WIDTH_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .clr_ni  (clr_ni),
  .q_o     (q_o),
  .q_no    (q_no),
  .fire_i  (fire),
  .eff_w_i (eff_w)
);

// File: tb/dual_edge_oneshot_tb_top.sv
`timescale 1ns/1ps
module dual_edge_oneshot_tb_top;
  localparam int WW = 10;
  localparam int RW = 6;
  localparam int CW = 6;
  localparam int WMAX = (1 << WW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_n = 1'b1;
  logic a_n = 1'b1;
  logic b = 1'b0;
  logic rc_mode = 1'b0;
  logic [WW-1:0] width = '0;
  logic [RW-1:0] r_val = '0;
  logic [CW-1:0] c_val = '0;
  logic q, q_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_edge_oneshot #(.WIDTH_W(WW), .R_W(RW), .C_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(clr_n), .trig_a_ni(a_n), .trig_b_i(b),
    .rc_mode_i(rc_mode), .width_i(width), .r_val_i(r_val), .c_val_i(c_val),
    .q_o(q), .q_no(q_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_direct(input int w);
    return (w == 0) ? 1 : w;
  endfunction

  function automatic int exp_rc(input int r, input int c);
    int v;
    v = (r * c * 179 + 128) >> 8;
    if (v > WMAX) v = WMAX;
    if (v == 0) v = 1;
    return v;
  endfunction

  // Start from idle (a_n=1, b=0) at a negedge; fire via A (use_b=0) or B.
  task automatic pulse(input bit use_b, input int hold, input bit tog, input int clr_at,
                       input int new_w, input int win,
                       output int cnt, output int first, output bit comp_ok);
    if (use_b) a_n = 1'b0; else b = 1'b1;
    repeat (4) @(negedge clk);
    if (use_b) b = 1'b1; else a_n = 1'b0;
    cnt = 0; first = -1; comp_ok = 1'b1;
    for (int i = 1; i <= win; i++) begin
      @(negedge clk);
      if (q) begin
        cnt++;
        if (first < 0) first = i;
      end
      if (q_n !== ~q) comp_ok = 1'b0;
      if (i == hold) begin
        if (use_b) b = 1'b0; else a_n = 1'b1;
      end
      if (tog && i >= 4 && i <= 11) begin
        if (use_b) b = i[0]; else a_n = i[0];
      end
      if (i == new_w) width = WW'(i + 17);
      if (i == clr_at) begin
        clr_n = 1'b0;
        #1;
        chk(q == 1'b0 && q_n == 1'b1, "R6 immediate clear", int'(q), 0);
      end
      if (clr_at > 0 && i == clr_at + 4) clr_n = 1'b1;
    end
    clr_n = 1'b1;
    if (use_b) begin
      b = 1'b0; @(negedge clk); a_n = 1'b1;
    end else begin
      a_n = 1'b1; @(negedge clk); b = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  int cnt, first, e;
  bit cok;

  initial begin
    #12;
    chk(q == 1'b0 && q_n == 1'b1, "R1 reset state", int'(q), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 / R8: direct width sweep through trigger A, includes zero
    for (int w = 0; w <= 40; w++) begin
      width = WW'(w); e = exp_direct(w);
      pulse(1'b0, 0, 1'b0, 0, 0, e + 10, cnt, first, cok);
      chk(cnt == e, "R2 R8 length via A", cnt, e);
      chk(first == 3, "R2 start latency via A", first, 3);
      chk(cok, "R12 complement", int'(cok), 1);
    end
    // R3: same sweep through trigger B
    for (int w = 0; w <= 40; w++) begin
      width = WW'(w); e = exp_direct(w);
      pulse(1'b1, 0, 1'b0, 0, 0, e + 10, cnt, first, cok);
      chk(cnt == e, "R3 length via B", cnt, e);
      chk(first == 3, "R3 start latency via B", first, 3);
    end

    // R4: inhibit by A high, then by B low
    width = WW'(5);
    cnt = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); b = ~b;
      repeat (3) begin @(negedge clk); if (q) cnt++; end
    end
    b = 1'b0; repeat (4) @(negedge clk);
    chk(cnt == 0, "R4 A high blocks B", cnt, 0);
    cnt = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); a_n = ~a_n;
      repeat (3) begin @(negedge clk); if (q) cnt++; end
    end
    a_n = 1'b1; repeat (4) @(negedge clk);
    chk(cnt == 0, "R4 B low blocks A", cnt, 0);

    // R5: retrigger attempts during a pulse
    width = WW'(20);
    pulse(1'b0, 0, 1'b1, 0, 0, 40, cnt, first, cok);
    chk(cnt == 20, "R5 no retrigger via A", cnt, 20);
    pulse(1'b1, 0, 1'b1, 0, 0, 40, cnt, first, cok);
    chk(cnt == 20, "R5 no retrigger via B", cnt, 20);

    // R6: clear mid pulse, highs sampled on indices 3..8
    width = WW'(30);
    pulse(1'b0, 0, 1'b0, 8, 0, 45, cnt, first, cok);
    chk(cnt == 6, "R6 clear cuts pulse", cnt, 6);
    chk(cok, "R12 complement under clear", int'(cok), 1);

    // R7: trigger edge while clear low, then release
    width = WW'(8);
    b = 1'b1; repeat (4) @(negedge clk);
    clr_n = 1'b0; @(negedge clk); a_n = 1'b0;
    repeat (5) @(negedge clk); clr_n = 1'b1;
    cnt = 0;
    repeat (15) begin @(negedge clk); if (q) cnt++; end
    chk(cnt == 0, "R7 no pulse after clear release", cnt, 0);
    a_n = 1'b1; @(negedge clk); b = 1'b0; repeat (4) @(negedge clk);

    // R9: width changed during pulse (new value set at index 5)
    width = WW'(9);
    pulse(1'b0, 0, 1'b0, 0, 5, 25, cnt, first, cok);
    chk(cnt == 9, "R9 width latched", cnt, 9);

    // R10: short and long trigger hold
    width = WW'(12);
    pulse(1'b0, 1, 1'b0, 0, 0, 22, cnt, first, cok);
    chk(cnt == 12, "R10 short hold", cnt, 12);
    pulse(1'b1, 1, 1'b0, 0, 0, 22, cnt, first, cok);
    chk(cnt == 12, "R10 short hold via B", cnt, 12);
    pulse(1'b0, 30, 1'b0, 0, 0, 22, cnt, first, cok);
    chk(cnt == 12, "R10 long hold", cnt, 12);

    // R11: helper mode grid including zero and saturation corners
    rc_mode = 1'b1; width = WW'(3);
    for (int r = 0; r <= 63; r += 9) begin
      for (int c = 0; c <= 63; c += 7) begin
        r_val = RW'(r); c_val = CW'(c); e = exp_rc(r, c);
        pulse(1'b0, 0, 1'b0, 0, 0, e + 10, cnt, first, cok);
        chk(cnt == e, "R11 helper width", cnt, e);
      end
    end
    r_val = RW'(63); c_val = CW'(63); e = exp_rc(63, 63);
    pulse(1'b1, 0, 1'b0, 0, 0, e + 10, cnt, first, cok);
    chk(cnt == e, "R11 helper saturation", cnt, e);
    rc_mode = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule